// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the programmable feedback divider of a frequency synthesizer. It is clocked by the output of an external prescaler that divides the VCO signal by either 32 or 33. The block decides which of the two moduli the prescaler uses in each of its periods. One complete divide cycle lasts M prescaler periods. The first S of these periods use divide-by-33 and the rest use divide-by-32. The total ratio from VCO edges to comparison strobes is therefore 33·S + 32·(M−S), which equals 32·M + S.

Two counters run from the prescaler clock. A down-counter for the main count sets the length of the cycle. A down-counter for the swallow count holds the modulus control high until it runs out. Both counters reload from the configuration inputs only at the cycle boundary. A single-period strobe marks that boundary for the phase detector. The valid settings are M from 32 to 4095 and S from 0 to 31, with M greater than S. These give ratios up to 131071.

Top module: `pulse_swallow_div`

## Requirements
- R1: While `rst` is high at the prescaler clock edges, `mod_hi` and `cmp_strobe` are both 0.
- R2: The number of VCO edges between consecutive rising edges of `cmp_strobe` equals 32·M + S, where M is `main_cfg` and S is `swal_cfg` as loaded at the boundary that opened the cycle.
- R3: `mod_hi` (1 selects divide-by-33, 0 selects divide-by-32) is high for the first S prescaler periods of every divide cycle and low for the rest of the cycle. This gives exactly 33·S VCO cycles with `mod_hi` high per divide cycle.
- R4: With S = 0, `mod_hi` stays low for the whole divide cycle.
- R5: `cmp_strobe` is high for exactly one prescaler period, the first period of each divide cycle. That is 33 VCO cycles when S > 0 and 32 VCO cycles when S = 0.
- R6: Changes on `main_cfg` or `swal_cfg` during a cycle do not alter that cycle. They take effect from the next boundary.
- R7: With a valid setting (S < M), `mod_hi` is low during the final prescaler period of the cycle. The smallest main count, M = 32 with S = 31, gives a ratio of 1055.
- R8: The ratio 10052 is produced by M = 314 (12'b000100111010) and S = 4 (5'b00100).
- R9: After `rst` falls, the first prescaler clock edge is a cycle boundary. `cmp_strobe` rises on that edge, within one prescaler period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pre | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| main_cfg | input | MAIN_W (12) | Main count M, sampled at each cycle boundary |
| swal_cfg | input | SWL_W (5) | Swallow count S, sampled at each cycle boundary |
| mod_hi | output | 1 | Modulus control to prescaler: 1 = divide by 33, 0 = divide by 32 |
| cmp_strobe | output | 1 | One-period strobe at the start of each divide cycle |

## Verification
A main counter that skips or repeats a state moves the strobe by a multiple of 32 VCO edges. A swallow counter that is off by one moves it by exactly one edge. Both errors therefore show in the very next strobe-to-strobe interval. The bench counts VCO edges between strobes and counts the VCO cycles spent with the modulus control high. A premature reload or a late release of the modulus control is visible within one divide cycle. Reload errors that happen mid-cycle are exposed by changing the settings mid-cycle and checking that the cycle in flight keeps its old length.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

    localparam int MAIN_W_DEF = 12;
    localparam int SWL_W_DEF  = 5;

    // Modulus request toward the prescaler
    typedef enum logic {
        MOD_DIV_P  = 1'b0,
        MOD_DIV_P1 = 1'b1
    } mod_e;

    // Status that the two counters hand to the top level
    typedef struct packed {
        logic expire;
        logic swallow_on;
    } ctr_status_t;

    function automatic mod_e pick_mod(input logic swallow_busy);
        return swallow_busy ? MOD_DIV_P1 : MOD_DIV_P;
    endfunction

endpackage

// File: rtl/pswd_main_ctr.sv
module pswd_main_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    assign expire = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (expire) begin
            cnt_q <= load_val - W'(1);
        end else begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    AST_MAIN_STEP: assert property (@(posedge clk) disable iff (rst)
        !expire |=> (cnt_q == $past(cnt_q) - W'(1))); // R2

    AST_MAIN_HOLD_CFG: assert property (@(posedge clk) disable iff (rst)
        (!expire && !$stable(load_val)) |=> (cnt_q != $past(load_val) - W'(1)) || (cnt_q == $past(cnt_q) - W'(1))); // R6

endmodule

// File: rtl/pswd_swallow_ctr.sv
module pswd_swallow_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         active
);
    logic [W-1:0] cnt_q;

    assign active = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (active) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    AST_SWALLOW_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!load && !active) |=> !active); // R3

    AST_SWALLOW_ZERO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (load && load_val == '0) |=> !active); // R4

endmodule

// File: rtl/pswd_strobe_gen.sv
module pswd_strobe_gen (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    output logic strobe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            strobe <= 1'b0;
        end else begin
            strobe <= expire;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe); // R5

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import pswd_pkg::*;
#(
    parameter int MAIN_W = MAIN_W_DEF,
    parameter int SWL_W  = SWL_W_DEF
) (
    input  logic              clk_pre,
    input  logic              rst,
    input  logic [MAIN_W-1:0] main_cfg,
    input  logic [SWL_W-1:0]  swal_cfg,
    output logic              mod_hi,
    output logic              cmp_strobe
);
    ctr_status_t st;
    mod_e        mod_sel;

    pswd_main_ctr #(.W(MAIN_W)) main_i (
        .clk      (clk_pre),
        .rst      (rst),
        .load_val (main_cfg),
        .expire   (st.expire)
    );

    pswd_swallow_ctr #(.W(SWL_W)) swallow_i (
        .clk      (clk_pre),
        .rst      (rst),
        .load     (st.expire),
        .load_val (swal_cfg),
        .active   (st.swallow_on)
    );

    pswd_strobe_gen strobe_i (
        .clk    (clk_pre),
        .rst    (rst),
        .expire (st.expire),
        .strobe (cmp_strobe)
    );

    assign mod_sel = pick_mod(st.swallow_on);
    assign mod_hi  = (mod_sel == MOD_DIV_P1);

    AST_RESET_QUIET: assert property (@(posedge clk_pre)
        $past(rst) |-> (!mod_hi && !cmp_strobe)); // R1

    AST_MOD_START: assert property (@(posedge clk_pre) disable iff (rst)
        (st.expire && swal_cfg != '0) |=> (mod_hi && cmp_strobe)); // R3

    AST_LAST_PERIOD_LOW: assert property (@(posedge clk_pre) disable iff (rst)
        st.expire |-> !mod_hi); // R7

endmodule

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;

    logic        clk = 1'b0;      // VCO-rate clock, 250 MHz
    logic        rst = 1'b1;
    logic [11:0] main_cfg = 12'd40;
    logic [4:0]  swal_cfg = 5'd5;
    logic        mod_hi;
    logic        cmp_strobe;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    // Prescaler model: modulus latched mid-period from mod_hi
    logic [5:0] pre_cnt = '0;
    logic [5:0] pre_mod = 6'd32;
    logic       clk_pre;
    assign clk_pre = (pre_cnt < 6'd16);

    always @(posedge clk) begin
        if (pre_cnt == 6'd16) pre_mod <= mod_hi ? 6'd33 : 6'd32;
        if (pre_cnt == pre_mod - 6'd1) pre_cnt <= '0;
        else pre_cnt <= pre_cnt + 6'd1;
    end

    pulse_swallow_div dut_i (
        .clk_pre    (clk_pre),
        .rst        (rst),
        .main_cfg   (main_cfg),
        .swal_cfg   (swal_cfg),
        .mod_hi     (mod_hi),
        .cmp_strobe (cmp_strobe)
    );

    // Monitor: VCO edges per cycle, high-modulus cycles, strobe width
    int edges = 0;
    int last_edge = 0;
    int hi_acc = 0, w_acc = 0;
    int meas_n = 0, meas_hi = 0, meas_w = 0;
    int ncyc = 0;
    logic strobe_d = 1'b0;

    always @(posedge clk) edges++;

    always @(negedge clk) begin
        if (cmp_strobe && !strobe_d) begin
            meas_n    = edges - last_edge;
            meas_hi   = hi_acc;
            meas_w    = w_acc;
            last_edge = edges;
            hi_acc    = mod_hi ? 1 : 0;
            w_acc     = 1;
            ncyc++;
        end else begin
            hi_acc += mod_hi ? 1 : 0;
            w_acc  += cmp_strobe ? 1 : 0;
        end
        strobe_d = cmp_strobe;
    end

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_strobes(input int k);
        int target = ncyc + k;
        while (ncyc < target) @(negedge clk);
    endtask

    task automatic test_reset();
        repeat (400) @(negedge clk);
        check("R1 strobe in reset", int'(cmp_strobe), 0);
        check("R1 mod_hi in reset", int'(mod_hi), 0);
        rst = 1'b0;
        begin
            int dly = 0;
            while (!cmp_strobe && dly < 100) begin
                @(negedge clk);
                dly++;
            end
            check("R9 first strobe within a period", int'(dly <= 33), 1);
        end
    endtask

    task automatic run_ratio(input int m, input int s, input string tag);
        @(negedge clk);
        main_cfg = 12'(m);
        swal_cfg = 5'(s);
        wait_strobes(2);
        check({tag, " ratio"}, meas_n, 32 * m + s);
        check((s == 0) ? "R4 mod_hi cycles" : "R3 mod_hi cycles", meas_hi, 33 * s);
        check("R5 strobe width", meas_w, (s > 0) ? 33 : 32);
    endtask

    task automatic test_midcycle_change();
        run_ratio(40, 5, "R2");
        wait_strobes(1);
        repeat (300) @(negedge clk);
        main_cfg = 12'd60;
        swal_cfg = 5'd7;
        wait_strobes(1);
        check("R6 cycle in flight keeps old ratio", meas_n, 32 * 40 + 5);
        wait_strobes(1);
        check("R6 new ratio from next boundary", meas_n, 32 * 60 + 7);
    endtask

    initial begin
        test_reset();
        run_ratio(40, 5, "R2");
        run_ratio(50, 0, "R4");
        run_ratio(32, 31, "R7");
        run_ratio(314, 4, "R8");
        check("R8 decomposition", 32 * 12'b000100111010 + 5'b00100, 10052);
        test_midcycle_change();
        run_ratio(100, 31, "R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule